// File: doc/BRIEF.md
# Banked Internal Data RAM

This block holds the 256-byte working data memory of an 8-bit microcontroller core. Each cycle it takes at most one access request. The request names one of four access kinds: a direct byte access, an indirect byte access, a register-operand access, or a single-bit access. A decoder turns the request into a byte address, and for bit accesses also into a bit position. A flop array then reads or writes that location.

Only the lower half of the memory can be reached with a direct address. A direct byte access, or a bit access, whose address has bit 7 set is not served from RAM. Instead the block raises a routing flag in the same cycle, so the core can steer that access to its special-function-register file. Register operands select one of four 8-byte banks by a 2-bit bank select. A 16-byte window starting at byte 20h can be read and written one bit at a time.

The storage array has no reset, so its contents are undefined until software writes them. Read data appears one cycle after the request. A write takes effect at the clock edge that samples it.

Top module: `iram_bank_unit`

## Requirements
- R1: A direct access (`kind_i`=0) with `addr_i` below 80h reads or writes byte `addr_i`. Read data appears on `rdata_o` with `rvalid_o`=1 in the cycle after the request.
- R2: An indirect access (`kind_i`=1) reaches any byte 00h–FFh and never raises `sfr_route_o`.
- R3: A direct access with `addr_i[7]`=1 raises `sfr_route_o` in the request cycle. It neither changes RAM nor produces `rvalid_o`.
- R4: A register access (`kind_i`=2) resolves to byte address {`bank_sel_i`[1:0], `reg_num_i`[2:0]}, so bank 0 is 00h–07h, bank 1 is 08h–0Fh, bank 2 is 10h–17h and bank 3 is 18h–1Fh.
- R5: A bit access (`kind_i`=3) with `addr_i` below 80h targets byte 20h+`addr_i`[6:3], bit `addr_i`[2:0]. A bit write changes only that bit. A bit read returns the bit on `bit_rdata_o` and the whole byte on `rdata_o`.
- R6: A bit access with `addr_i[7]`=1 raises `sfr_route_o`. It neither changes RAM nor produces `rvalid_o`.
- R7: After reset `rvalid_o`, `rdata_o` and `bit_rdata_o` are 0. `rvalid_o` is 1 exactly in the cycle after a RAM read request (`req_i`=1, `we_i`=0, not routed).
- R8: A write is visible to a read issued in the very next cycle. `rdata_o` holds its value while no RAM read is issued, and `bit_rdata_o` changes only on bit reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (output registers only) |
| req_i | input | 1 | Access request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| kind_i | input | 2 | 0 direct, 1 indirect, 2 register, 3 bit |
| addr_i | input | 8 | Byte address (direct/indirect) or bit address (bit) |
| reg_num_i | input | 3 | Register number for register access |
| bank_sel_i | input | 2 | Active register bank |
| wdata_i | input | 8 | Byte write data |
| bit_wdata_i | input | 1 | Bit write data |
| rdata_o | output | 8 | Byte read data, one cycle latency |
| bit_rdata_o | output | 1 | Bit read data, one cycle latency |
| rvalid_o | output | 1 | Read data valid |
| sfr_route_o | output | 1 | Request belongs to the special-function-register port |

## Verification
All 256 bytes are first loaded indirectly with random data, so that every later read has a known value. A random mix of the four access kinds then runs, with random banks, register numbers and full 8-bit addresses. This mix shows whether bank bases, bit-window offsets and bit positions are decoded correctly, because a wrong mapping reads a neighbour with different random contents. Directed cases cover the corners. Each bank's R7 is written and read back indirectly. The bit addresses 00h and 7Fh are tested. A routed direct write or bit write is followed by a RAM read at the location a missing upper-half guard would hit, which shows whether routed accesses leak into RAM. Idle cycles between reads check that the output is held.

// File: rtl/iram_pkg.sv
package iram_pkg;
  typedef enum logic [1:0] {
    ACC_DIRECT   = 2'd0,
    ACC_INDIRECT = 2'd1,
    ACC_REG      = 2'd2,
    ACC_BIT      = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/iram_addr_map.sv
module iram_addr_map
  import iram_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int REG_W    = 3,
  parameter int BANK_W   = 2,
  parameter int BIT_BASE = 32'h20
) (
  input  acc_kind_e                   kind_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [REG_W-1:0]            reg_num_i,
  input  logic [BANK_W-1:0]           bank_sel_i,
  output logic [ADDR_W-1:0]           byte_addr_o,
  output logic [$clog2(DATA_W)-1:0]   bit_pos_o,
  output logic                        sfr_o
);
  localparam int POS_W  = $clog2(DATA_W);
  localparam int PAD_W  = ADDR_W - BANK_W - REG_W;
  localparam int HALF_B = ADDR_W - 1;

  logic [ADDR_W-1:0] bit_off;
  assign bit_off = ADDR_W'(addr_i[HALF_B-1:POS_W]);

  always_comb begin
    byte_addr_o = addr_i;
    bit_pos_o   = '0;
    sfr_o       = 1'b0;
    unique case (kind_i)
      ACC_DIRECT:   sfr_o = addr_i[HALF_B];
      ACC_INDIRECT: sfr_o = 1'b0;
      ACC_REG:      byte_addr_o = {{PAD_W{1'b0}}, bank_sel_i, reg_num_i};
      ACC_BIT: begin
        byte_addr_o = ADDR_W'(BIT_BASE) + bit_off;
        bit_pos_o   = addr_i[POS_W-1:0];
        sfr_o       = addr_i[HALF_B];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/iram_store.sv
module iram_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       rd_en_i,
  input  logic                       wr_en_i,
  input  logic                       bit_mode_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [$clog2(DATA_W)-1:0]  pos_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic                       bit_wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic                       bit_rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // contents deliberately left unreset
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      if (bit_mode_i) mem_q[addr_i][pos_i] <= bit_wdata_i;
      else            mem_q[addr_i]        <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o     <= '0;
      bit_rdata_o <= 1'b0;
    end else if (rd_en_i) begin
      rdata_o <= mem_q[addr_i];
      if (bit_mode_i) bit_rdata_o <= mem_q[addr_i][pos_i];
    end
  end
endmodule

// File: rtl/iram_bank_unit.sv
module iram_bank_unit
  import iram_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int REG_W    = 3,
  parameter int BANK_W   = 2,
  parameter int BIT_BASE = 32'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  reg_num_i,
  input  logic [BANK_W-1:0] bank_sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              bit_wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bit_rdata_o,
  output logic              rvalid_o,
  output logic              sfr_route_o
);
  localparam int POS_W = $clog2(DATA_W);

  acc_kind_e         kind;
  logic [ADDR_W-1:0] byte_addr;
  logic [POS_W-1:0]  bit_pos;
  logic              sfr_hit, ram_rd, ram_wr;

  assign kind = acc_kind_e'(kind_i);

  iram_addr_map #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W),
    .BANK_W(BANK_W), .BIT_BASE(BIT_BASE)
  ) i_map (
    .kind_i      (kind),
    .addr_i      (addr_i),
    .reg_num_i   (reg_num_i),
    .bank_sel_i  (bank_sel_i),
    .byte_addr_o (byte_addr),
    .bit_pos_o   (bit_pos),
    .sfr_o       (sfr_hit)
  );

  assign sfr_route_o = req_i & sfr_hit;
  assign ram_rd      = req_i & ~we_i & ~sfr_hit;
  assign ram_wr      = req_i &  we_i & ~sfr_hit;

  iram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_en_i     (ram_rd),
    .wr_en_i     (ram_wr),
    .bit_mode_i  (kind == ACC_BIT),
    .addr_i      (byte_addr),
    .pos_i       (bit_pos),
    .wdata_i     (wdata_i),
    .bit_wdata_i (bit_wdata_i),
    .rdata_o     (rdata_o),
    .bit_rdata_o (bit_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rvalid_o <= 1'b0;
    else         rvalid_o <= ram_rd;
  end

  assert_route_no_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfr_route_o |=> !rvalid_o);

  assert_bit_upper_route_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && kind == ACC_BIT && addr_i[ADDR_W-1]) |-> sfr_route_o);

  assert_indirect_local_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == ACC_INDIRECT) |-> !sfr_route_o);

  assert_bank_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == ACC_REG) |-> (byte_addr < ADDR_W'(1 << (BANK_W + REG_W))));

  assert_bit_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == ACC_BIT && !sfr_hit) |->
      (byte_addr >= ADDR_W'(BIT_BASE) &&
       byte_addr <  ADDR_W'(BIT_BASE + (1 << (ADDR_W - 1 - POS_W)))));

  assert_valid_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_rd |=> rvalid_o);

  assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_rd |=> ($stable(rdata_o) && $stable(bit_rdata_o)));
endmodule

// File: tb/test_iram_bank_unit.sv
module test_iram_bank_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0, bwd = 1'b0;
  logic [1:0] kind = 2'd0;
  logic [7:0] addr = '0, wd = '0;
  logic [2:0] regn = '0;
  logic [1:0] bank = '0;
  logic [7:0] rdata;
  logic       bit_rdata, rvalid, sfr_route;

  int n_chk = 0, n_err = 0;
  logic [7:0] m [256];
  logic [7:0] last_rd = '0;
  logic       last_bit = 1'b0;

  always #4 clk = ~clk;

  iram_bank_unit i_iram_bank_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .kind_i(kind),
    .addr_i(addr), .reg_num_i(regn), .bank_sel_i(bank), .wdata_i(wd),
    .bit_wdata_i(bwd), .rdata_o(rdata), .bit_rdata_o(bit_rdata),
    .rvalid_o(rvalid), .sfr_route_o(sfr_route)
  );

  function automatic logic [7:0] exp_byte(logic [1:0] k, logic [7:0] a,
                                          logic [2:0] r, logic [1:0] b);
    case (k)
      2'd2:    return {3'b000, b, r};
      2'd3:    return 8'h20 + {4'h0, a[6:3]};
      default: return a;
    endcase
  endfunction

  function automatic logic exp_sfr(logic [1:0] k, logic [7:0] a);
    return (k == 2'd0 || k == 2'd3) && a[7];
  endfunction

  task automatic chk(logic ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic op(logic [1:0] k, logic w, logic [7:0] a, logic [2:0] r,
                    logic [1:0] b, logic [7:0] d, logic bd, string tag);
    logic [7:0] ea;
    logic       es;
    ea = exp_byte(k, a, r, b);
    es = exp_sfr(k, a);
    req = 1'b1; we = w; kind = k; addr = a; regn = r; bank = b; wd = d; bwd = bd;
    #1;
    chk(sfr_route === es, tag, 32'(sfr_route), 32'(es));
    @(negedge clk);
    req = 1'b0;
    chk(rvalid === (!w && !es), tag, 32'(rvalid), 32'(!w && !es));
    if (!w && !es) begin
      last_rd = m[ea];
      if (k == 2'd3) last_bit = m[ea][a[2:0]];
    end
    chk(rdata === last_rd, tag, 32'(rdata), 32'(last_rd));
    chk(bit_rdata === last_bit, tag, 32'(bit_rdata), 32'(last_bit));
    if (w && !es) begin
      if (k == 2'd3) m[ea][a[2:0]] = bd;
      else           m[ea] = d;
    end
  endtask

  task automatic idle(string tag);
    req = 1'b0;
    @(negedge clk);
    chk(rvalid === 1'b0, tag, 32'(rvalid), 0);
    chk(rdata === last_rd, tag, 32'(rdata), 32'(last_rd));
    chk(bit_rdata === last_bit, tag, 32'(bit_rdata), 32'(last_bit));
  endtask

  initial begin
    #(8 * 190000);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd8051));
    repeat (3) @(negedge clk);
    chk(rvalid === 1'b0 && rdata === 8'h00 && bit_rdata === 1'b0, "R7 reset",
        {rvalid, bit_rdata, rdata}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // preload through indirect writes (R2)
    for (int i = 0; i < 256; i++) op(2'd1, 1'b1, 8'(i), 3'd0, 2'd0, 8'($urandom), 1'b0, "R2 fill");
    for (int i = 0; i < 256; i += 17) op(2'd1, 1'b0, 8'(i), 3'd0, 2'd0, 8'h0, 1'b0, "R2 read");

    // R4: R7 of every bank, checked indirectly
    for (int b = 0; b < 4; b++) begin
      op(2'd2, 1'b1, 8'h0, 3'd7, 2'(b), 8'(8'hA0 + b), 1'b0, "R4 bank write");
      op(2'd1, 1'b0, 8'(b * 8 + 7), 3'd0, 2'd0, 8'h0, 1'b0, "R4 bank readback");
    end

    // R5 window edges
    op(2'd3, 1'b1, 8'h7F, 3'd0, 2'd0, 8'h0, ~m[8'h2F][7], "R5 bit 7Fh write");
    op(2'd1, 1'b0, 8'h2F, 3'd0, 2'd0, 8'h0, 1'b0, "R5 byte 2Fh");
    op(2'd3, 1'b1, 8'h00, 3'd0, 2'd0, 8'h0, ~m[8'h20][0], "R5 bit 00h write");
    op(2'd3, 1'b0, 8'h00, 3'd0, 2'd0, 8'h0, 1'b0, "R5 bit 00h read");

    // R6: bit 80h would alias bit 00h if not routed
    op(2'd3, 1'b1, 8'h80, 3'd0, 2'd0, 8'h0, ~m[8'h20][0], "R6 bit 80h write");
    op(2'd3, 1'b0, 8'h00, 3'd0, 2'd0, 8'h0, 1'b0, "R6 alias check");
    op(2'd3, 1'b0, 8'hFF, 3'd0, 2'd0, 8'h0, 1'b0, "R6 bit FFh read");

    // R3: direct 85h routed, indirect 85h and low 05h untouched
    op(2'd0, 1'b1, 8'h85, 3'd0, 2'd0, ~m[8'h85], 1'b0, "R3 direct upper write");
    op(2'd1, 1'b0, 8'h85, 3'd0, 2'd0, 8'h0, 1'b0, "R3 upper intact");
    op(2'd0, 1'b0, 8'h05, 3'd0, 2'd0, 8'h0, 1'b0, "R3 lower intact");
    op(2'd0, 1'b0, 8'hC0, 3'd0, 2'd0, 8'h0, 1'b0, "R3 direct upper read");

    // R1 / R8: back-to-back write then read, then idle hold
    op(2'd0, 1'b1, 8'h7F, 3'd0, 2'd0, 8'h5A, 1'b0, "R1 direct write");
    op(2'd0, 1'b0, 8'h7F, 3'd0, 2'd0, 8'h0, 1'b0, "R8 next-cycle read");
    idle("R8 hold");
    idle("R8 hold");

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] k;
      string t;
      k = 2'($urandom);
      case (k)
        2'd0: t = "R1 random direct";
        2'd1: t = "R2 random indirect";
        2'd2: t = "R4 random register";
        default: t = "R5 random bit";
      endcase
      op(k, 1'($urandom), 8'($urandom), 3'($urandom), 2'($urandom),
         8'($urandom), 1'($urandom), t);
      if ($urandom % 8 == 0) idle("R8 random idle");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule